// File: doc/BRIEF.md
# Masked Z80 I/O Port Decoder

This block watches the I/O cycles of a Z80-style bus and decides whether the current port access belongs to one peripheral. Address bits 1 and up, and the level of the M1 line, are each compared against a per-bit condition. A condition can demand a low level, demand a high level, or ignore the bit. Because bits can be ignored individually, the matched set of ports need not be contiguous, so aliased ("ghost") port ranges are possible. Address bit 0 is never compared, so any match covers at least one aligned pair of ports.

The conditions sit in a small bank of clocked configuration registers. Software loads them one field at a time through a write port. Everything else is combinational. The block produces four active-low strobes: a device enable, a device read, a device write and an interrupt acknowledge. These follow the bus control lines in the same cycle.

Top module: `io_port_decoder`

## Requirements
- R1: After reset, every address field holds don't-care and the M1 field holds must-be-high. With that configuration the enable asserts for every port whenever iorq_n is low and m1_n is high.
- R2: Field codes are 2'b00 = the line must be low, 2'b01 = the line must be high, and 2'b10 or 2'b11 = don't care. A write with cfg_we high at a rising clk edge loads cfg_data into the field chosen by cfg_idx. Index 0 is the M1 field and index k (k ≥ 1) is address bit k. The new value governs decoding from that edge on.
- R3: The level of addr[0] never changes any output.
- R4: dev_en_n is low exactly when iorq_n is low and every configured condition holds for the current addr and m1_n.
- R5: dev_rd_n is low exactly when dev_en_n is low and rd_n is low.
- R6: dev_wr_n is low exactly when dev_en_n is low and wr_n is low.
- R7: int_ack_n is low exactly when both m1_n and iorq_n are low, whatever the configuration and address.
- R8: While the M1 field is must-be-high, dev_en_n stays high whenever m1_n is low.
- R9: With bits 7..3 set to 0,0,1,0,0 and bits 2..1 set to don't-care, the enable asserts for ports 0x20 to 0x27 only.
- R10: The four outputs follow changes of the bus inputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | IDX_W (3) | Field index: 0 = M1, k = address bit k |
| cfg_data | input | 2 | Field code |
| addr | input | ADDR_W (8) | Port address lines |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read, active low |
| wr_n | input | 1 | Write, active low |
| m1_n | input | 1 | Opcode-fetch/acknowledge marker, active low |
| dev_en_n | output | 1 | Device enable, active low |
| dev_rd_n | output | 1 | Device read strobe, active low |
| dev_wr_n | output | 1 | Device write strobe, active low |
| int_ack_n | output | 1 | Interrupt acknowledge, active low |

## Verification
The device enable and the interrupt acknowledge can both be active in one cycle. This happens when the M1 field is set to don't-care or must-be-low and the bus runs an acknowledge, meaning m1_n and iorq_n are both low while the address matches. The bench creates this case by sweeping every port with all sixteen control-line combinations under those M1 settings, and expects both strobes low together. Under the reset M1 setting the same stimulus must produce only the acknowledge.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

   typedef logic [1:0] cond_t;

   localparam cond_t COND_LO = 2'b00;
   localparam cond_t COND_HI = 2'b01;
   localparam cond_t COND_DC = 2'b10;

   // a condition holds when it is don't-care or its low bit equals the line level
   function automatic logic cond_ok(input cond_t c, input logic lvl);
      return c[1] | (c[0] == lvl);
   endfunction

endpackage

// File: rtl/io_dec_cfg_regs.sv
module io_dec_cfg_regs
   import io_dec_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [IDX_W-1:0]        idx,
   input  cond_t                   wdata,
   output cond_t [ADDR_W-1:0]      fields
);

   generate
      for (genvar k = 0; k < ADDR_W; k++) begin : g_field
         localparam cond_t RST_VAL = (k == 0) ? COND_HI : COND_DC;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               fields[k] <= RST_VAL;
            else if (we && (int'(idx) == k))
               fields[k] <= wdata;
         end
      end
   endgenerate

endmodule

// File: rtl/io_dec_bit_match.sv
module io_dec_bit_match
   import io_dec_pkg::*;
(
   input  cond_t cond,
   input  logic  lvl,
   output logic  ok
);

   always_comb ok = cond_ok(cond, lvl);

endmodule

// File: rtl/io_dec_strobes.sv
module io_dec_strobes (
   input  logic all_ok,
   input  logic iorq_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic m1_n,
   output logic dev_en_n,
   output logic dev_rd_n,
   output logic dev_wr_n,
   output logic int_ack_n
);

   logic en;

   always_comb begin
      en        = all_ok & ~iorq_n;
      dev_en_n  = ~en;
      dev_rd_n  = ~(en & ~rd_n);
      dev_wr_n  = ~(en & ~wr_n);
      int_ack_n = ~(~m1_n & ~iorq_n);
   end

endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
   import io_dec_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = $clog2(ADDR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [1:0]        cfg_data,
   input  logic [ADDR_W-1:0] addr,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              m1_n,
   output logic              dev_en_n,
   output logic              dev_rd_n,
   output logic              dev_wr_n,
   output logic              int_ack_n
);

   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_width
         $error("io_port_decoder: ADDR_W must lie in 2..16");
      end
      if ((1 << IDX_W) < ADDR_W) begin : g_bad_idx
         $error("io_port_decoder: IDX_W too narrow to address every field");
      end
   endgenerate

   cond_t [ADDR_W-1:0] cfg_q;
   logic  [ADDR_W-1:0] ok_vec;
   logic               all_ok;

   io_dec_cfg_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .idx    (cfg_idx),
      .wdata  (cfg_data),
      .fields (cfg_q)
   );

   // field 0 carries the M1 condition; addr[0] has no matcher at all
   generate
      for (genvar k = 0; k < ADDR_W; k++) begin : g_match
         if (k == 0) begin : g_m1
            io_dec_bit_match i_m (.cond(cfg_q[0]), .lvl(m1_n), .ok(ok_vec[0]));
         end else begin : g_addr
            io_dec_bit_match i_m (.cond(cfg_q[k]), .lvl(addr[k]), .ok(ok_vec[k]));
         end
      end
   endgenerate

   always_comb all_ok = &ok_vec;

   io_dec_strobes i_strb (
      .all_ok    (all_ok),
      .iorq_n    (iorq_n),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .m1_n      (m1_n),
      .dev_en_n  (dev_en_n),
      .dev_rd_n  (dev_rd_n),
      .dev_wr_n  (dev_wr_n),
      .int_ack_n (int_ack_n)
   );

endmodule

// File: rtl/io_port_decoder_chk.sv
module io_port_decoder_chk #(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_we,
   input logic [IDX_W-1:0]        cfg_idx,
   input logic [1:0]              cfg_data,
   input logic                    iorq_n,
   input logic                    rd_n,
   input logic                    wr_n,
   input logic                    m1_n,
   input logic                    dev_en_n,
   input logic                    dev_rd_n,
   input logic                    dev_wr_n,
   input logic                    int_ack_n,
   input logic [ADDR_W-1:0][1:0]  cfg_q
);

   // R1
   reset_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (cfg_q[0] == 2'b01 && cfg_q[ADDR_W-1][1]));

   // R2
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(cfg_idx) < ADDR_W) |=> (cfg_q[$past(cfg_idx)] == $past(cfg_data)));

   // R4
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iorq_n |-> (dev_en_n && dev_rd_n && dev_wr_n && int_ack_n));

   // R5
   rd_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_rd_n |-> (!dev_en_n && !rd_n));

   // R6
   wr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_wr_n |-> (!dev_en_n && !wr_n));

   // R7
   ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!m1_n && !iorq_n) |-> !int_ack_n);

   // R8
   m1_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[0] == 2'b01 && !m1_n) |-> dev_en_n);

endmodule

bind io_port_decoder io_port_decoder_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_idx   (cfg_idx),
   .cfg_data  (cfg_data),
   .iorq_n    (iorq_n),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .m1_n      (m1_n),
   .dev_en_n  (dev_en_n),
   .dev_rd_n  (dev_rd_n),
   .dev_wr_n  (dev_wr_n),
   .int_ack_n (int_ack_n),
   .cfg_q     (cfg_q)
);

// File: tb/test_io_port_decoder.sv
`timescale 1ns/100ps
module test_io_port_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_idx = '0;
   logic [1:0] cfg_data = '0;
   logic [7:0] addr = '0;
   logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
   logic       dev_en_n, dev_rd_n, dev_wr_n, int_ack_n;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [1:0] mcfg [8];   // bench's own view of the configured fields

   always #2.5 clk = ~clk;

   io_port_decoder i_io_port_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
      .addr(addr), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
      .dev_en_n(dev_en_n), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .int_ack_n(int_ack_n)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s addr=%02h iorq_n=%b m1_n=%b rd_n=%b wr_n=%b actual=%b expected=%b",
                  tag, what, addr, iorq_n, m1_n, rd_n, wr_n, act, exp);
      end
   endtask

   function automatic logic ok_cond(input logic [1:0] c, input logic lvl);
      return c[1] | (c[0] == lvl);
   endfunction

   task automatic wr_cfg(input int idx, input logic [1:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_data = val;
      @(negedge clk);
      cfg_we = 1'b0;
      mcfg[idx] = val;
   endtask

   task automatic sweep(input string en_tag, input bit window);
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 16; b++) begin
            logic match, en, ack;
            string t;
            addr = 8'(a);
            {iorq_n, m1_n, rd_n, wr_n} = 4'(b);
            #1;
            match = ok_cond(mcfg[0], m1_n);
            for (int k = 1; k < 8; k++) match &= ok_cond(mcfg[k], addr[k]);
            en  = match & ~iorq_n;
            ack = ~m1_n & ~iorq_n;
            if (mcfg[0] == 2'b01 && !m1_n) t = "R8";
            else if (addr[0]) t = "R3";
            else t = en_tag;
            chk(t, "dev_en_n", dev_en_n, ~en);
            if (window && m1_n) chk("R9", "window", dev_en_n, ~(~iorq_n && a >= 'h20 && a <= 'h27));
            chk("R5", "dev_rd_n", dev_rd_n, ~(en & ~rd_n));
            chk("R6", "dev_wr_n", dev_wr_n, ~(en & ~wr_n));
            chk("R7", "int_ack_n", int_ack_n, ~ack);
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      mcfg[0] = 2'b01;
      for (int k = 1; k < 8; k++) mcfg[k] = 2'b10;
      #1;
      chk("R1", "reset idle dev_en_n", dev_en_n, 1'b1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset configuration, every port selected outside acknowledge
      sweep("R1", 1'b0);

      // R9: window 0x20..0x27
      wr_cfg(7, 2'b00); wr_cfg(6, 2'b00); wr_cfg(5, 2'b01);
      wr_cfg(4, 2'b00); wr_cfg(3, 2'b00);
      sweep("R9", 1'b1);

      // R10: read strobe follows rd_n mid-cycle with no clock edge
      @(posedge clk); #0.5;
      addr = 8'h23; iorq_n = 1'b0; m1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      #0.5; chk("R10", "rd idle", dev_rd_n, 1'b1);
      rd_n = 1'b0; #0.5; chk("R10", "rd asserted", dev_rd_n, 1'b0);
      rd_n = 1'b1; #0.5; chk("R10", "rd released", dev_rd_n, 1'b1);
      iorq_n = 1'b1;

      // R2: ghost pattern using 2'b11 as don't-care and bit-level constraints
      wr_cfg(7, 2'b01); wr_cfg(6, 2'b11); wr_cfg(5, 2'b11);
      wr_cfg(4, 2'b01); wr_cfg(3, 2'b11); wr_cfg(2, 2'b00); wr_cfg(1, 2'b01);
      sweep("R2", 1'b0);

      // R4: M1 don't-care lets enable and acknowledge coincide
      wr_cfg(0, 2'b10);
      sweep("R4", 1'b0);

      // R4: M1 must-be-low decodes only during acknowledge
      wr_cfg(0, 2'b00);
      sweep("R4", 1'b0);

      finish_run();
   end

endmodule